// File: doc/BRIEF.md
# Processor Trace Status Encoder

This block turns instruction retirement events from a processor pipeline into a real-time trace stream. The stream has two 4-bit outputs: a status code and a data nibble. Each accepted retirement becomes one trace record. A record starts with a status code. Optional operand values and an optional change-of-flow target address may follow it. Each value is announced by a marker code on the status output. Its bytes then follow on the data output, least-significant nibble first, one nibble per cycle. While a data nibble is on the data output, the status output reads 0.

Records are held in a small record queue. This lets a burst of operand data drain while later instructions retire. When the queue is full, the block lowers its ready output and the pipeline must hold its retirement.

Two configuration inputs gate operand display and target display independently. The display of each value is decided when the record is accepted. That decision depends on the configuration inputs, on the addressing mode of a jump-class instruction, and on whether a move-multiple transfer is line-sized.

Top module: `trc_encoder`

## Requirements
- R1: With no record pending, `pst` and `ddata` are both 0. After reset, `rdy` is 1.
- R2: Every accepted record begins with one status slot. The code is 0xC when `exc_vld` is set. Otherwise it is 0x4 when `ret_spec` is set, and 0x1 in all other cases.
- R3: A displayed operand gives one marker slot: `pst` = 0x8 for size 2'b00 (byte), 0x9 for size 2'b01 (word), 0xB for size 2'b10 or 2'b11 (long), with `ddata` = 0. It then gives 2, 4 or 8 data slots with `pst` = 0, carrying the value's nibbles least-significant first.
- R4: When both captures are displayed, the source capture (`src_*`) is sent completely before the destination capture (`dst_*`).
- R5: When `cof_vld` is set, a slot with `pst` = 0x5 follows the operands. If the target is displayed, a marker follows: 0x9 when bits 31:16 of the target are zero (4 nibbles), 0xA when only bits 31:24 are zero (6 nibbles), and 0xB otherwise (8 nibbles). The target nibbles come after the marker.
- R6: For a jump-class change of flow (`cof_jmp` = 1), the target is displayed only when `cof_mode` is 2, 3, 4 or 6. The 0x5 slot is still sent for every other mode.
- R7: When `mm_vld` = 1, `mm_addr` = 0 and `mm_cnt` >= 4, both operand captures are suppressed whatever the configuration inputs say.
- R8: `cfg_opnd` = 0 suppresses the operand markers and data. `cfg_tgt` = 0 suppresses the target marker and data. The status and 0x5 slots are still sent, and each bit acts independently of the other.
- R9: `rdy` is 0 while DEPTH records are held. Records are emitted in acceptance order, and no record's slots mix with another's.
- R10: A record accepted while the queue is empty shows its status slot on `pst` after the second rising edge following the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ret_vld | input | 1 | Instruction retires this cycle (accepted when `rdy` = 1) |
| ret_spec | input | 1 | Special instruction (status 0x4) |
| exc_vld | input | 1 | Exception entry (status 0xC) |
| src_vld | input | 1 | Source operand captured |
| src_sz | input | 2 | Source size: 0 byte, 1 word, 2/3 long |
| src_val | input | 32 | Source value |
| dst_vld | input | 1 | Destination operand captured |
| dst_sz | input | 2 | Destination size |
| dst_val | input | 32 | Destination value |
| mm_vld | input | 1 | Instruction is a move-multiple transfer |
| mm_addr | input | 4 | Low four bits of the transfer address |
| mm_cnt | input | 5 | Registers remaining in the transfer |
| cof_vld | input | 1 | Taken change of flow |
| cof_jmp | input | 1 | Change of flow is jump class (mode-dependent display) |
| cof_mode | input | 3 | Addressing mode of the jump target |
| cof_tgt | input | 32 | Target address |
| cfg_opnd | input | 1 | Enable operand display |
| cfg_tgt | input | 1 | Enable target display |
| rdy | output | 1 | Retirement can be accepted |
| pst | output | 4 | Status or marker code |
| ddata | output | 4 | Data nibble |

## Verification
A status slot is due exactly two rising edges after its accepting edge when the block is idle. The bench therefore stamps each such record with its due cycle and compares `pst` in that cycle. After the status slot, every slot of a record follows one cycle after the previous one. The scoreboard compares these slots strictly one per cycle and allows idle cycles only before a record's first slot. Queue-full behaviour is sampled in the cycle after the second of two back-to-back long records is accepted, before any of the first has drained.

// File: rtl/trc_pkg.sv
package trc_pkg;

    localparam int TRC_DW = 32;

    typedef struct packed {
        logic [3:0]        code;
        logic              s_en;
        logic [1:0]        s_sz;
        logic [TRC_DW-1:0] s_val;
        logic              d_en;
        logic [1:0]        d_sz;
        logic [TRC_DW-1:0] d_val;
        logic              cof;
        logic              t_en;
        logic [3:0]        t_mk;
        logic [TRC_DW-1:0] t_val;
    } trc_rec_t;

    typedef enum logic [3:0] {
        PH_ST, PH_SM, PH_SD, PH_DM, PH_DD, PH_CF, PH_TM, PH_TD, PH_END
    } trc_phase_t;

    function automatic logic [3:0] sz_mark(input logic [1:0] sz);
        case (sz)
            2'b00:   return 4'h8;
            2'b01:   return 4'h9;
            default: return 4'hB;
        endcase
    endfunction

    function automatic logic [3:0] sz_len(input logic [1:0] sz);
        case (sz)
            2'b00:   return 4'd2;
            2'b01:   return 4'd4;
            default: return 4'd8;
        endcase
    endfunction

    function automatic logic [3:0] mk_len(input logic [3:0] mk);
        case (mk)
            4'h9:    return 4'd4;
            4'hA:    return 4'd6;
            default: return 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/trc_capture.sv
module trc_capture
    import trc_pkg::*;
(
    input  logic              ret_spec,
    input  logic              exc_vld,
    input  logic              src_vld,
    input  logic [1:0]        src_sz,
    input  logic [TRC_DW-1:0] src_val,
    input  logic              dst_vld,
    input  logic [1:0]        dst_sz,
    input  logic [TRC_DW-1:0] dst_val,
    input  logic              mm_vld,
    input  logic [3:0]        mm_addr,
    input  logic [4:0]        mm_cnt,
    input  logic              cof_vld,
    input  logic              cof_jmp,
    input  logic [2:0]        cof_mode,
    input  logic [TRC_DW-1:0] cof_tgt,
    input  logic              cfg_opnd,
    input  logic              cfg_tgt,
    output trc_rec_t          rec
);

    logic line_xfer;
    logic mode_ok;

    always_comb begin
        line_xfer = mm_vld && (mm_addr == 4'd0) && (mm_cnt >= 5'd4);
        mode_ok   = !cof_jmp || (cof_mode == 3'd2) || (cof_mode == 3'd3)
                    || (cof_mode == 3'd4) || (cof_mode == 3'd6);

        rec.code  = exc_vld ? 4'hC : (ret_spec ? 4'h4 : 4'h1);
        rec.s_en  = src_vld && cfg_opnd && !line_xfer;
        rec.s_sz  = src_sz;
        rec.s_val = src_val;
        rec.d_en  = dst_vld && cfg_opnd && !line_xfer;
        rec.d_sz  = dst_sz;
        rec.d_val = dst_val;
        rec.cof   = cof_vld;
        rec.t_en  = cof_vld && cfg_tgt && mode_ok;
        rec.t_val = cof_tgt;
        if (cof_tgt[31:16] == 16'd0)      rec.t_mk = 4'h9;
        else if (cof_tgt[31:24] == 8'd0)  rec.t_mk = 4'hA;
        else                              rec.t_mk = 4'hB;
    end

endmodule

// File: rtl/trc_recq.sv
module trc_recq
    import trc_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  trc_rec_t din,
    input  logic     pop,
    output trc_rec_t dout,
    output logic     empty,
    output logic     full
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } q_state_t;

    q_state_t q_d, q_q;
    trc_rec_t mem_q [DEPTH];

    always_comb begin
        q_d = q_q;
        if (push) q_d.wp = (q_q.wp == PW'(DEPTH - 1)) ? '0 : q_q.wp + 1'b1;
        if (pop)  q_d.rp = (q_q.rp == PW'(DEPTH - 1)) ? '0 : q_q.rp + 1'b1;
        case ({push, pop})
            2'b10:   q_d.cnt = q_q.cnt + 1'b1;
            2'b01:   q_d.cnt = q_q.cnt - 1'b1;
            default: q_d.cnt = q_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[q_q.wp] <= din;
    end

    assign dout  = mem_q[q_q.rp];
    assign empty = (q_q.cnt == '0);
    assign full  = (q_q.cnt == CW'(DEPTH));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop |=> q_q.cnt == $past(q_q.cnt) + 1'b1 && q_q.cnt <= CW'(DEPTH)); // R9
    AST_POP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R9

endmodule

// File: rtl/trc_serial.sv
module trc_serial
    import trc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     head_vld,
    input  trc_rec_t head,
    output logic     pop,
    output logic [3:0] pst,
    output logic [3:0] ddata
);

    typedef struct packed {
        trc_phase_t phase;
        logic [2:0] nib;
        logic [3:0] pst;
        logic [3:0] dd;
    } s_state_t;

    s_state_t s_d, s_q;

    function automatic trc_phase_t nxt(input trc_rec_t r, input trc_phase_t p);
        trc_phase_t n;
        n = PH_END;
        case (p)
            PH_ST:   n = r.s_en ? PH_SM : (r.d_en ? PH_DM : (r.cof ? PH_CF : PH_END));
            PH_SM:   n = PH_SD;
            PH_SD:   n = r.d_en ? PH_DM : (r.cof ? PH_CF : PH_END);
            PH_DM:   n = PH_DD;
            PH_DD:   n = r.cof ? PH_CF : PH_END;
            PH_CF:   n = r.t_en ? PH_TM : PH_END;
            PH_TM:   n = PH_TD;
            default: n = PH_END;
        endcase
        return n;
    endfunction

    logic              adv;
    logic [3:0]        len;
    logic [TRC_DW-1:0] val;
    trc_phase_t        nph;

    always_comb begin
        s_d  = s_q;
        s_d.pst = 4'h0;
        s_d.dd  = 4'h0;
        adv  = 1'b0;
        pop  = 1'b0;
        len  = 4'd8;
        val  = head.t_val;
        case (s_q.phase)
            PH_SD:   begin len = sz_len(head.s_sz); val = head.s_val; end
            PH_DD:   begin len = sz_len(head.d_sz); val = head.d_val; end
            default: begin len = mk_len(head.t_mk); val = head.t_val; end
        endcase
        if (head_vld) begin
            case (s_q.phase)
                PH_ST: begin s_d.pst = head.code;          adv = 1'b1; end
                PH_SM: begin s_d.pst = sz_mark(head.s_sz); adv = 1'b1; end
                PH_DM: begin s_d.pst = sz_mark(head.d_sz); adv = 1'b1; end
                PH_CF: begin s_d.pst = 4'h5;               adv = 1'b1; end
                PH_TM: begin s_d.pst = head.t_mk;          adv = 1'b1; end
                PH_SD, PH_DD, PH_TD: begin
                    s_d.dd = val[{s_q.nib, 2'b00} +: 4];
                    if ({1'b0, s_q.nib} == len - 4'd1) adv = 1'b1;
                    else s_d.nib = s_q.nib + 3'd1;
                end
                default: adv = 1'b1;
            endcase
        end
        nph = nxt(head, s_q.phase);
        if (adv) begin
            s_d.nib = 3'd0;
            if (nph == PH_END) begin
                pop       = 1'b1;
                s_d.phase = PH_ST;
            end else begin
                s_d.phase = nph;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{phase: PH_ST, nib: 3'd0, pst: 4'h0, dd: 4'h0};
        else        s_q <= s_d;
    end

    assign pst   = s_q.pst;
    assign ddata = s_q.dd;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !head_vld |=> pst == 4'h0 && ddata == 4'h0); // R1
    AST_DATA_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        head_vld && (s_q.phase == PH_SD || s_q.phase == PH_DD || s_q.phase == PH_TD)
        |=> pst == 4'h0); // R3
    AST_NIB_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        head_vld && s_q.phase == PH_SD |-> {1'b0, s_q.nib} < sz_len(head.s_sz)); // R3

endmodule

// File: rtl/trc_encoder.sv
module trc_encoder
    import trc_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ret_vld,
    input  logic        ret_spec,
    input  logic        exc_vld,
    input  logic        src_vld,
    input  logic [1:0]  src_sz,
    input  logic [31:0] src_val,
    input  logic        dst_vld,
    input  logic [1:0]  dst_sz,
    input  logic [31:0] dst_val,
    input  logic        mm_vld,
    input  logic [3:0]  mm_addr,
    input  logic [4:0]  mm_cnt,
    input  logic        cof_vld,
    input  logic        cof_jmp,
    input  logic [2:0]  cof_mode,
    input  logic [31:0] cof_tgt,
    input  logic        cfg_opnd,
    input  logic        cfg_tgt,
    output logic        rdy,
    output logic [3:0]  pst,
    output logic [3:0]  ddata
);

    trc_rec_t new_rec;
    trc_rec_t head;
    logic     acc;
    logic     q_empty;
    logic     q_full;
    logic     pop;

    trc_capture u_cap (
        .ret_spec (ret_spec), .exc_vld (exc_vld),
        .src_vld  (src_vld),  .src_sz  (src_sz),  .src_val (src_val),
        .dst_vld  (dst_vld),  .dst_sz  (dst_sz),  .dst_val (dst_val),
        .mm_vld   (mm_vld),   .mm_addr (mm_addr), .mm_cnt  (mm_cnt),
        .cof_vld  (cof_vld),  .cof_jmp (cof_jmp), .cof_mode(cof_mode),
        .cof_tgt  (cof_tgt),  .cfg_opnd(cfg_opnd), .cfg_tgt (cfg_tgt),
        .rec      (new_rec)
    );

    assign acc = ret_vld && !q_full;
    assign rdy = !q_full;

    trc_recq #(.DEPTH(DEPTH)) u_q (
        .clk (clk), .rst_n (rst_n), .push (acc), .din (new_rec),
        .pop (pop), .dout (head), .empty (q_empty), .full (q_full)
    );

    trc_serial u_ser (
        .clk (clk), .rst_n (rst_n), .head_vld (!q_empty), .head (head),
        .pop (pop), .pst (pst), .ddata (ddata)
    );

    AST_STATUS_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        acc && q_empty |-> ##2 (pst == 4'h1 || pst == 4'h4 || pst == 4'hC)); // R10
    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> !rdy); // R9

endmodule

// File: tb/sim_trc_encoder.sv
module sim_trc_encoder;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        ret_vld = 0, ret_spec = 0, exc_vld = 0;
    logic        src_vld = 0, dst_vld = 0, mm_vld = 0;
    logic [1:0]  src_sz = 0, dst_sz = 0;
    logic [31:0] src_val = 0, dst_val = 0, cof_tgt = 0;
    logic [3:0]  mm_addr = 0;
    logic [4:0]  mm_cnt = 0;
    logic        cof_vld = 0, cof_jmp = 0;
    logic [2:0]  cof_mode = 0;
    logic        cfg_opnd = 1, cfg_tgt = 1;
    logic        rdy;
    logic [3:0]  pst, ddata;

    trc_encoder u0 (.*);

    typedef struct {
        logic [3:0] p;
        logic [3:0] d;
        bit         start;
        int         due;
        string      req;
    } slot_t;

    typedef struct {
        bit sp, ex, sv, dv, mm, cv, cj, co, ct;
        logic [1:0] ss, ds;
        logic [31:0] sval, dval, tgt;
        logic [3:0] ma;
        logic [4:0] mc;
        logic [2:0] cm;
    } stim_t;

    slot_t exp_q[$];
    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic stim_t base();
        stim_t s;
        s = '{sp:0, ex:0, sv:0, dv:0, mm:0, cv:0, cj:0, co:1, ct:1,
              ss:0, ds:0, sval:0, dval:0, tgt:0, ma:0, mc:0, cm:0};
        return s;
    endfunction

    function automatic int nlen(input logic [1:0] sz);
        return (sz == 2'b00) ? 2 : (sz == 2'b01) ? 4 : 8;
    endfunction

    function automatic logic [3:0] nmark(input logic [1:0] sz);
        return (sz == 2'b00) ? 4'h8 : (sz == 2'b01) ? 4'h9 : 4'hB;
    endfunction

    task automatic expect_slot(input logic [3:0] p, input logic [3:0] d,
                               input bit st, input int due, input string req);
        slot_t s;
        s = '{p:p, d:d, start:st, due:due, req:req};
        exp_q.push_back(s);
    endtask

    task automatic send(input stim_t s, input bit timed, input string req);
        bit line;
        bit showt;
        int n;
        logic [3:0] mk;
        @(negedge clk);
        while (!rdy) @(negedge clk);
        ret_vld = 1; ret_spec = s.sp; exc_vld = s.ex;
        src_vld = s.sv; src_sz = s.ss; src_val = s.sval;
        dst_vld = s.dv; dst_sz = s.ds; dst_val = s.dval;
        mm_vld = s.mm; mm_addr = s.ma; mm_cnt = s.mc;
        cof_vld = s.cv; cof_jmp = s.cj; cof_mode = s.cm; cof_tgt = s.tgt;
        cfg_opnd = s.co; cfg_tgt = s.ct;
        // R2 status code, R10 due two edges later when idle
        expect_slot(s.ex ? 4'hC : (s.sp ? 4'h4 : 4'h1), 4'h0, 1'b1,
                    timed ? cyc + 2 : -1, {req, "/R2"});
        line = s.mm && s.ma == 4'd0 && s.mc >= 5'd4;   // R7
        if (s.sv && s.co && !line) begin              // R3 R4 R8
            expect_slot(nmark(s.ss), 4'h0, 1'b0, -1, {req, "/R3"});
            for (int i = 0; i < nlen(s.ss); i++)
                expect_slot(4'h0, s.sval[4*i +: 4], 1'b0, -1, {req, "/R3"});
        end
        if (s.dv && s.co && !line) begin
            expect_slot(nmark(s.ds), 4'h0, 1'b0, -1, {req, "/R4"});
            for (int i = 0; i < nlen(s.ds); i++)
                expect_slot(4'h0, s.dval[4*i +: 4], 1'b0, -1, {req, "/R4"});
        end
        if (s.cv) begin                               // R5 R6
            expect_slot(4'h5, 4'h0, 1'b0, -1, {req, "/R5"});
            showt = s.ct && (!s.cj || s.cm == 3'd2 || s.cm == 3'd3
                             || s.cm == 3'd4 || s.cm == 3'd6);
            if (showt) begin
                if (s.tgt[31:16] == 0)      begin mk = 4'h9; n = 4; end
                else if (s.tgt[31:24] == 0) begin mk = 4'hA; n = 6; end
                else                        begin mk = 4'hB; n = 8; end
                expect_slot(mk, 4'h0, 1'b0, -1, {req, "/R5"});
                for (int i = 0; i < n; i++)
                    expect_slot(4'h0, s.tgt[4*i +: 4], 1'b0, -1, {req, "/R5"});
            end
        end
        @(negedge clk);
        ret_vld = 0;
    endtask

    task automatic settle();
        wait (exp_q.size() == 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: compares one slot per cycle against the scoreboard
    always @(negedge clk) begin
        if (rst_n && exp_q.size() > 0) begin
            slot_t h;
            h = exp_q[0];
            if (h.start && h.due >= 0 && cyc < h.due) begin
            end else if (h.start && h.due < 0 && pst == 4'h0 && ddata == 4'h0) begin
            end else begin
                void'(exp_q.pop_front());
                chk(pst == h.p && ddata == h.d, h.req, {pst, ddata}, {h.p, h.d});
                if (h.start && h.due >= 0)
                    chk(cyc == h.due, "R10 due cycle", cyc, h.due);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        stim_t s;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(pst == 0 && ddata == 0, "R1 reset outputs", {pst, ddata}, 0);
        chk(rdy == 1, "R1 reset rdy", rdy, 1);

        s = base(); send(s, 1, "R2 plain"); settle();
        s = base(); s.sp = 1; s.sv = 1; s.ss = 2'b01; s.sval = 32'h0000BEEF;
        send(s, 1, "R2 special word"); settle();
        s = base(); s.sv = 1; s.ss = 2'b00; s.sval = 32'h5A; s.dv = 1; s.ds = 2'b10;
        s.dval = 32'h12345678; send(s, 1, "R4 rmw"); settle();
        s.co = 0; send(s, 1, "R8 opnd off"); settle();
        s = base(); s.cv = 1; s.tgt = 32'h00001234; s.sv = 1; s.ss = 2'b11;
        s.sval = 32'hCAFEF00D; send(s, 1, "R5 two bytes"); settle();
        s = base(); s.cv = 1; s.tgt = 32'h00ABCDEF; send(s, 1, "R5 three bytes"); settle();
        s.tgt = 32'h89ABCDEF; send(s, 1, "R5 four bytes"); settle();
        s.cj = 1; s.cm = 3'd1; send(s, 1, "R6 absolute mode"); settle();
        s.cm = 3'd6; send(s, 1, "R6 pc indexed"); settle();
        s.cm = 3'd3; send(s, 1, "R6 disp16"); settle();
        s = base(); s.cv = 1; s.ct = 0; s.tgt = 32'h4000; s.sv = 1; s.ss = 2'b01;
        s.sval = 32'h1357; send(s, 1, "R8 tgt off"); settle();
        s = base(); s.mm = 1; s.ma = 4'd0; s.mc = 5'd4; s.sv = 1; s.ss = 2'b10;
        s.sval = 32'hA5A5A5A5; send(s, 1, "R7 line burst"); settle();
        s.mc = 5'd3; send(s, 1, "R7 few regs"); settle();
        s.ma = 4'd8; s.mc = 5'd6; send(s, 1, "R7 unaligned"); settle();
        s = base(); s.ex = 1; s.dv = 1; s.ds = 2'b10; s.dval = 32'h0BADC0DE;
        s.cv = 1; s.tgt = 32'h00002468; send(s, 1, "R2 exception"); settle();
        chk(pst == 0 && ddata == 0, "R1 idle after drain", {pst, ddata}, 0);

        // R9: two long records fill the queue; the third waits
        s = base(); s.sv = 1; s.ss = 2'b10; s.sval = 32'h11112222; s.dv = 1;
        s.ds = 2'b10; s.dval = 32'h33334444; s.cv = 1; s.tgt = 32'h55556666;
        send(s, 0, "R9 first");
        s.sval = 32'h77778888; send(s, 0, "R9 second");
        chk(rdy == 0, "R9 rdy low when full", rdy, 0);
        s.sp = 1; s.sval = 32'h9999AAAA; send(s, 0, "R9 third");
        settle();
        chk(rdy == 1, "R9 rdy after drain", rdy, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule